// File: doc/BRIEF.md
# Key-Gated Indexed Configuration Port

This block is a byte-wide register file reached through two I/O locations: an index location (`io_addr` = 0) and a data location (`io_addr` = 1). Out of reset the block is locked in a run state, where all index and data traffic is ignored. Writing an unlock key to the index location opens configuration. After that, an index write picks a register, and any number of later data-location reads or writes reach that register. Writing a lock key to the index location closes configuration again.

A logical-device-number register picks which bank sits behind the per-device indices. Each implemented device bank stores an activate bit, two 16-bit base addresses and two interrupt selects. These drive per-device enable, base and interrupt outputs continuously. Banks keep their contents while other devices are selected. One further logical number selects a bank of auxiliary bytes instead of a device bank.

The control is a three-state machine:
- `ST_RUN`: locked.
- `ST_CFG_OPEN`: unlocked, but no index has been chosen.
- `ST_CFG_SEL`: unlocked, with an index latched.

Its transitions are:
- `T_UNLOCK` (`ST_RUN` to `ST_CFG_OPEN`) on an index write of the unlock key.
- `T_SELECT` (`ST_CFG_OPEN` to `ST_CFG_SEL`) on an index write of any other byte.
- `T_RESELECT` (`ST_CFG_SEL` to `ST_CFG_SEL`) on a further index write.
- `T_LOCK` (either configuration state to `ST_RUN`) on an index write of the lock key.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset the block is in run state. All device enables, bases and interrupt selects are 0, and a data-location read returns 0xFF.
- R2: In run state, data-location writes change nothing and data-location reads return 0xFF. An index write of any byte other than 0x55 leaves the block locked, and so does a write of 0x55 to the data location.
- R3: An index write of 0x55 in run state unlocks the block. Until the next index write, data reads return 0xFF and data writes are discarded.
- R4: An index write of 0xAA in either configuration state relocks the block. Afterwards data writes have no effect and data reads return 0xFF.
- R5: Index 0x20 reads 0x30 and index 0x21 reads 0x01. Writes to either index are discarded.
- R6: Index 0x07 holds the logical device number as a full byte that reads back as written. All per-device indices act on the bank that this number selects.
- R7: Index 0x30 bit 0 is the selected device's activate bit. It reads back as 0x00 or 0x01, and `dev_enable[n]` follows it from the cycle after the write.
- R8: Index 0x60 and index 0x61 are the high and low bytes of base 0. Index 0x62 and index 0x63 are the high and low bytes of base 1. Each base drives `dev_base0` or `dev_base1` at bits [16n+15:16n] from the cycle after the write.
- R9: Index 0x70 and index 0x72 hold the selected device's primary and secondary interrupt selects. They drive `dev_irq0` and `dev_irq1` at bits [8n+7:8n].
- R10: Only logical numbers 1, 2, 3, 4, 5 and 7 have device banks. Each bank keeps its values while other numbers are selected. With any other number selected, per-device writes are discarded and per-device reads return 0x00.
- R11: With logical number 8 selected, indices 0xC0 to 0xEF are read/write auxiliary bytes. With any other number selected, those indices read 0x00 and writes to them are discarded. With number 8 selected, per-device indices read 0x00.
- R12: Every index not named above reads 0x00, and writes to it are discarded.
- R13: The latched index persists, so repeated data accesses without a new index write all reach the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Write strobe for one cycle |
| io_rd | input | 1 | Read strobe; `io_rdata` is valid in the same cycle |
| io_addr | input | 1 | 0 = index location, 1 = data location |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Read byte (combinational) |
| dev_enable | output | 8 | Activate bit per logical number |
| dev_base0 | output | 128 | Base 0 per logical number, 16 bits each |
| dev_base1 | output | 128 | Base 1 per logical number, 16 bits each |
| dev_irq0 | output | 64 | Primary interrupt select per logical number |
| dev_irq1 | output | 64 | Secondary interrupt select per logical number |

## Verification
A data read is combinational from the latched state, so the bench samples `io_rdata` in the same cycle it raises `io_rd`, well before the next rising edge. Every write, whether to the index or the data location, takes effect at the rising edge that samples it. The bench therefore checks device outputs and state-dependent reads at the following falling edge, one cycle after the write. The readback sweep covers every logical number from 0 to 9 and every index except the lock key. For each pair it writes the index first and reads in the next cycle, and it compares the result against a value derived from the bytes the bench itself wrote.

// File: rtl/keyed_cfg_pkg.sv
package keyed_cfg_pkg;

    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_CFG_OPEN = 2'd1,
        ST_CFG_SEL  = 2'd2
    } cfg_state_e;

    localparam logic [7:0] IX_LDN    = 8'h07;
    localparam logic [7:0] IX_DEVID  = 8'h20;
    localparam logic [7:0] IX_DEVREV = 8'h21;
    localparam logic [7:0] IX_ACT    = 8'h30;
    localparam logic [7:0] IX_B0_HI  = 8'h60;
    localparam logic [7:0] IX_B0_LO  = 8'h61;
    localparam logic [7:0] IX_B1_HI  = 8'h62;
    localparam logic [7:0] IX_B1_LO  = 8'h63;
    localparam logic [7:0] IX_IRQ0   = 8'h70;
    localparam logic [7:0] IX_IRQ1   = 8'h72;

endpackage

// File: rtl/keyed_cfg_fsm.sv
module keyed_cfg_fsm
    import keyed_cfg_pkg::*;
#(
    parameter logic [7:0] KEY_UNLOCK = 8'h55,
    parameter logic [7:0] KEY_LOCK   = 8'hAA
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output cfg_state_e state,
    output logic [7:0] index,
    output logic       data_en
);

    cfg_state_e state_q, state_d;
    logic [7:0] index_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (idx_wr && wdata == KEY_UNLOCK) state_d = ST_CFG_OPEN;   // T_UNLOCK
            end
            ST_CFG_OPEN, ST_CFG_SEL: begin
                if (idx_wr) begin
                    if (wdata == KEY_LOCK) state_d = ST_RUN;                // T_LOCK
                    else                   state_d = ST_CFG_SEL;            // T_SELECT / T_RESELECT
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    // latched index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_q <= 8'h00;
        end else if (state_q == ST_RUN) begin
            index_q <= 8'h00;
        end else if (idx_wr && wdata != KEY_LOCK) begin
            index_q <= wdata;
        end
    end

    // outputs
    always_comb begin
        state   = state_q;
        index   = index_q;
        data_en = (state_q == ST_CFG_SEL);
    end

    AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !(idx_wr && wdata == KEY_UNLOCK)) |=> state_q == ST_RUN); // R2
    AST_UNLOCK_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && idx_wr && wdata == KEY_UNLOCK) |=> state_q == ST_CFG_OPEN); // R3
    AST_LOCK_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN && idx_wr && wdata == KEY_LOCK) |=> state_q == ST_RUN); // R4
    AST_INDEX_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CFG_SEL && !idx_wr) |=> $stable(index_q)); // R13

endmodule

// File: rtl/keyed_cfg_dev_bank.sv
module keyed_cfg_dev_bank
    import keyed_cfg_pkg::*;
#(
    parameter int BASE_W = 16,
    parameter int IRQ_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        index,
    input  logic [7:0]        wdata,
    output logic [7:0]        rd_byte,
    output logic              act,
    output logic [BASE_W-1:0] base0,
    output logic [BASE_W-1:0] base1,
    output logic [IRQ_W-1:0]  irq0,
    output logic [IRQ_W-1:0]  irq1
);

    logic              act_q;
    logic [BASE_W-1:0] base0_q, base1_q;
    logic [IRQ_W-1:0]  irq0_q, irq1_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= 1'b0;
            base0_q <= '0;
            base1_q <= '0;
            irq0_q  <= '0;
            irq1_q  <= '0;
        end else if (wr_en) begin
            case (index)
                IX_ACT:   act_q          <= wdata[0];
                IX_B0_HI: base0_q[15:8]  <= wdata;
                IX_B0_LO: base0_q[7:0]   <= wdata;
                IX_B1_HI: base1_q[15:8]  <= wdata;
                IX_B1_LO: base1_q[7:0]   <= wdata;
                IX_IRQ0:  irq0_q         <= wdata[IRQ_W-1:0];
                IX_IRQ1:  irq1_q         <= wdata[IRQ_W-1:0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (index)
            IX_ACT:   rd_byte = {7'b0, act_q};
            IX_B0_HI: rd_byte = base0_q[15:8];
            IX_B0_LO: rd_byte = base0_q[7:0];
            IX_B1_HI: rd_byte = base1_q[15:8];
            IX_B1_LO: rd_byte = base1_q[7:0];
            IX_IRQ0:  rd_byte = 8'(irq0_q);
            IX_IRQ1:  rd_byte = 8'(irq1_q);
            default:  rd_byte = 8'h00;
        endcase
    end

    assign act   = act_q;
    assign base0 = base0_q;
    assign base1 = base1_q;
    assign irq0  = irq0_q;
    assign irq1  = irq1_q;

    AST_ACT_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && index == IX_ACT) |=> act == $past(wdata[0])); // R7
    AST_ACT_RETAINED: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && index == IX_ACT) |=> $stable(act)); // R10
    AST_BASE0_RETAINED: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(base0)); // R10

endmodule

// File: rtl/keyed_cfg_aux_bank.sv
module keyed_cfg_aux_bank #(
    parameter logic [7:0] AUX_FIRST = 8'hC0,
    parameter int         AUX_COUNT = 48
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] index,
    input  logic [7:0] wdata,
    output logic [7:0] rd_byte
);

    localparam int AW = (AUX_COUNT > 1) ? $clog2(AUX_COUNT) : 1;
    localparam logic [8:0] AUX_END = 9'(AUX_FIRST) + 9'(AUX_COUNT);

    logic [7:0] mem_q [AUX_COUNT];
    logic       in_range;
    logic [7:0] off_full;
    logic [AW-1:0] off;

    assign in_range = (index >= AUX_FIRST) && ({1'b0, index} < AUX_END);
    assign off_full = index - AUX_FIRST;
    assign off      = off_full[AW-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < AUX_COUNT; i++) mem_q[i] <= 8'h00;
        end else if (wr_en && in_range) begin
            mem_q[off] <= wdata;
        end
    end

    assign rd_byte = in_range ? mem_q[off] : 8'h00;

    AST_AUX_OUT_OF_RANGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !in_range |-> rd_byte == 8'h00); // R12

endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
    import keyed_cfg_pkg::*;
#(
    parameter int            NUM_LDN    = 8,
    parameter logic [7:0]    VALID_LDN  = 8'hBE,
    parameter logic [7:0]    AUX_LDN    = 8'h08,
    parameter logic [7:0]    AUX_FIRST  = 8'hC0,
    parameter int            AUX_COUNT  = 48,
    parameter logic [7:0]    DEV_ID     = 8'h30,
    parameter logic [7:0]    DEV_REV    = 8'h01,
    parameter logic [7:0]    KEY_UNLOCK = 8'h55,
    parameter logic [7:0]    KEY_LOCK   = 8'hAA,
    parameter int            BASE_W     = 16,
    parameter int            IRQ_W      = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      io_wr,
    input  logic                      io_rd,
    input  logic                      io_addr,
    input  logic [7:0]                io_wdata,
    output logic [7:0]                io_rdata,
    output logic [NUM_LDN-1:0]        dev_enable,
    output logic [NUM_LDN*BASE_W-1:0] dev_base0,
    output logic [NUM_LDN*BASE_W-1:0] dev_base1,
    output logic [NUM_LDN*IRQ_W-1:0]  dev_irq0,
    output logic [NUM_LDN*IRQ_W-1:0]  dev_irq1
);

    cfg_state_e state;
    logic [7:0] index;
    logic       data_en;
    logic       idx_wr, dat_wr;
    logic [7:0] ldn_q;
    logic [7:0] bank_rd [NUM_LDN];
    logic [7:0] dev_rd, aux_rd;

    assign idx_wr = io_wr && !io_addr;
    assign dat_wr = io_wr && io_addr && data_en;

    keyed_cfg_fsm #(
        .KEY_UNLOCK (KEY_UNLOCK),
        .KEY_LOCK   (KEY_LOCK)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_wr  (idx_wr),
        .wdata   (io_wdata),
        .state   (state),
        .index   (index),
        .data_en (data_en)
    );

    // logical device number
    always_ff @(posedge clk) begin
        if (!rst_n)                          ldn_q <= 8'h00;
        else if (dat_wr && index == IX_LDN)  ldn_q <= io_wdata;
    end

    for (genvar g = 0; g < NUM_LDN; g++) begin : g_bank
        if (VALID_LDN[g]) begin : g_real
            keyed_cfg_dev_bank #(
                .BASE_W (BASE_W),
                .IRQ_W  (IRQ_W)
            ) u_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (dat_wr && ldn_q == 8'(g)),
                .index   (index),
                .wdata   (io_wdata),
                .rd_byte (bank_rd[g]),
                .act     (dev_enable[g]),
                .base0   (dev_base0[g*BASE_W +: BASE_W]),
                .base1   (dev_base1[g*BASE_W +: BASE_W]),
                .irq0    (dev_irq0[g*IRQ_W +: IRQ_W]),
                .irq1    (dev_irq1[g*IRQ_W +: IRQ_W])
            );
        end else begin : g_none
            assign bank_rd[g]                   = 8'h00;
            assign dev_enable[g]                = 1'b0;
            assign dev_base0[g*BASE_W +: BASE_W] = '0;
            assign dev_base1[g*BASE_W +: BASE_W] = '0;
            assign dev_irq0[g*IRQ_W +: IRQ_W]    = '0;
            assign dev_irq1[g*IRQ_W +: IRQ_W]    = '0;
        end
    end

    keyed_cfg_aux_bank #(
        .AUX_FIRST (AUX_FIRST),
        .AUX_COUNT (AUX_COUNT)
    ) u_aux (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (dat_wr && ldn_q == AUX_LDN),
        .index   (index),
        .wdata   (io_wdata),
        .rd_byte (aux_rd)
    );

    always_comb begin
        dev_rd = 8'h00;
        for (int g = 0; g < NUM_LDN; g++) begin
            if (ldn_q == 8'(g)) dev_rd = bank_rd[g];
        end
    end

    // read mux
    always_comb begin
        if (!data_en) begin
            io_rdata = 8'hFF;
        end else begin
            case (index)
                IX_LDN:    io_rdata = ldn_q;
                IX_DEVID:  io_rdata = DEV_ID;
                IX_DEVREV: io_rdata = DEV_REV;
                default:   io_rdata = (ldn_q == AUX_LDN) ? aux_rd : dev_rd;
            endcase
        end
    end

    AST_LOCKED_READS_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr && state == ST_RUN) |-> io_rdata == 8'hFF); // R2
    AST_LDN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !(dat_wr && index == IX_LDN) |=> $stable(ldn_q)); // R6
    AST_RUN_NO_ENABLE_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |=> $stable(dev_enable)); // R4

endmodule

// File: tb/test_keyed_cfg_port.sv
`timescale 1ns/1ps
module test_keyed_cfg_port;

    localparam logic [7:0] VALID = 8'hBE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0, io_rd = 1'b0, io_addr = 1'b0;
    logic [7:0]  io_wdata = 8'h00;
    logic [7:0]  io_rdata;
    logic [7:0]  dev_enable;
    logic [127:0] dev_base0, dev_base1;
    logic [63:0] dev_irq0, dev_irq1;

    int compared = 0;
    int mismatched = 0;

    logic        sh_act [8];
    logic [15:0] sh_b0 [8], sh_b1 [8];
    logic [7:0]  sh_i0 [8], sh_i1 [8];
    logic [7:0]  sh_aux [48];

    always #5 clk = ~clk;

    keyed_cfg_port i_keyed_cfg_port (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .dev_enable(dev_enable),
        .dev_base0(dev_base0), .dev_base1(dev_base1),
        .dev_irq0(dev_irq0), .dev_irq1(dev_irq1)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(posedge clk);
        #1 io_wr = 1'b0;
    endtask

    task automatic rd(output logic [7:0] v);
        @(negedge clk);
        io_addr = 1'b1; io_rd = 1'b1;
        #2 v = io_rdata;
        @(posedge clk);
        #1 io_rd = 1'b0;
    endtask

    task automatic set_reg(input logic [7:0] ix, input logic [7:0] d);
        wr(1'b0, ix);
        wr(1'b1, d);
    endtask

    function automatic logic [7:0] expect_byte(input int ldn, input int ix);
        if (ix == 8'h07) return 8'(ldn);
        if (ix == 8'h20) return 8'h30;
        if (ix == 8'h21) return 8'h01;
        if (ldn == 8) return (ix >= 8'hC0 && ix <= 8'hEF) ? sh_aux[ix - 8'hC0] : 8'h00;
        if (ldn < 8 && VALID[ldn]) begin
            case (ix)
                8'h30: return {7'b0, sh_act[ldn]};
                8'h60: return sh_b0[ldn][15:8];
                8'h61: return sh_b0[ldn][7:0];
                8'h62: return sh_b1[ldn][15:8];
                8'h63: return sh_b1[ldn][7:0];
                8'h70: return sh_i0[ldn];
                8'h72: return sh_i1[ldn];
                default: return 8'h00;
            endcase
        end
        return 8'h00;
    endfunction

    task automatic check_outputs(input string req);
        @(negedge clk);
        for (int g = 0; g < 8; g++) begin
            chk({req, " enable"}, 32'(dev_enable[g]), 32'(sh_act[g]));
            chk({req, " base0"}, 32'(dev_base0[g*16 +: 16]), 32'(sh_b0[g]));
            chk({req, " base1"}, 32'(dev_base1[g*16 +: 16]), 32'(sh_b1[g]));
            chk({req, " irq0"}, 32'(dev_irq0[g*8 +: 8]), 32'(sh_i0[g]));
            chk({req, " irq1"}, 32'(dev_irq1[g*8 +: 8]), 32'(sh_i1[g]));
        end
    endtask

    initial begin
        #1_000_000;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [7:0] v;
        for (int g = 0; g < 8; g++) begin
            sh_act[g] = 1'b0; sh_b0[g] = 16'h0; sh_b1[g] = 16'h0; sh_i0[g] = 8'h0; sh_i1[g] = 8'h0;
        end
        for (int i = 0; i < 48; i++) sh_aux[i] = 8'h00;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        check_outputs("R1");
        rd(v); chk("R1 locked read", 32'(v), 32'hFF);

        // R2 run state ignores traffic
        wr(1'b0, 8'h07); wr(1'b1, 8'h01);
        wr(1'b0, 8'h30); wr(1'b1, 8'h01);
        wr(1'b1, 8'h55);
        rd(v); chk("R2 run read", 32'(v), 32'hFF);
        check_outputs("R2");

        // R3 unlock, no index yet
        wr(1'b0, 8'h55);
        rd(v); chk("R3 open read", 32'(v), 32'hFF);
        wr(1'b1, 8'h04);
        wr(1'b0, 8'h07);
        rd(v); chk("R3 open write dropped", 32'(v), 32'h00);

        // R5 identity
        set_reg(8'h20, 8'h99);
        rd(v); chk("R5 id", 32'(v), 32'h30);
        set_reg(8'h21, 8'h77);
        rd(v); chk("R5 rev", 32'(v), 32'h01);

        // R12 unimplemented index
        set_reg(8'h41, 8'h5C);
        rd(v); chk("R12 unimplemented", 32'(v), 32'h00);

        // program every logical number 0..9
        for (int n = 0; n < 10; n++) begin
            set_reg(8'h07, 8'(n));
            rd(v); chk("R6 ldn readback", 32'(v), 32'(n));
            rd(v); chk("R13 repeat read", 32'(v), 32'(n));
            set_reg(8'h30, n[0] ? 8'h01 : 8'hFE);
            set_reg(8'h60, 8'(8'h10 + n)); set_reg(8'h61, 8'(n * 17));
            set_reg(8'h62, 8'(8'h03));     set_reg(8'h63, 8'(n * 7 + 2));
            set_reg(8'h70, 8'(n + 3));     set_reg(8'h72, 8'(n * 5 + 1));
            set_reg(8'hC5, 8'(8'hE0 + n));
            if (n < 8 && VALID[n]) begin
                sh_act[n] = n[0];
                sh_b0[n]  = {8'(8'h10 + n), 8'(n * 17)};
                sh_b1[n]  = {8'h03, 8'(n * 7 + 2)};
                sh_i0[n]  = 8'(n + 3);
                sh_i1[n]  = 8'(n * 5 + 1);
            end
            if (n == 8) begin
                sh_aux[5] = 8'(8'hE0 + n);
                for (int i = 0; i < 48; i++) begin
                    if (i != 5) begin
                        set_reg(8'(8'hC0 + i), 8'(i) ^ 8'h5A);
                        sh_aux[i] = 8'(i) ^ 8'h5A;
                    end
                end
            end
        end
        check_outputs("R8 R9 R10");

        // readback sweep over all logical numbers and indices
        for (int n = 0; n < 10; n++) begin
            set_reg(8'h07, 8'(n));
            for (int ix = 0; ix < 256; ix++) begin
                if (ix != 8'hAA) begin
                    wr(1'b0, 8'(ix));
                    rd(v);
                    chk("R7 R8 R9 R10 R11 R12 sweep", 32'(v), 32'(expect_byte(n, ix)));
                end
            end
        end

        // R4 lock, then data writes ignored
        set_reg(8'h07, 8'h01);
        wr(1'b0, 8'h30);
        wr(1'b0, 8'hAA);
        rd(v); chk("R4 locked read", 32'(v), 32'hFF);
        wr(1'b1, 8'h00);
        check_outputs("R4");

        // R3 again: reopen, data write before index dropped
        wr(1'b0, 8'h55);
        wr(1'b1, 8'h00);
        check_outputs("R3 reopen");
        wr(1'b0, 8'h30);
        rd(v); chk("R3 act kept", 32'(v), 32'h01);
        wr(1'b0, 8'hAA);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule